// File: doc/BRIEF.md
# Background Integer Divider with Full/Empty Result Registers

This block is a 32-bit integer divider that sits beside an in-order pipeline and runs on its own. The pipeline hands it a dividend, a divisor and a flag that selects signed or unsigned operation. The divider then works through a fixed number of cycles without further help. When it finishes, it writes the quotient into a LO result register and the remainder into a HI result register. Each result register has a full bit. Issuing a divide clears both bits, and completion sets them again.

The pipeline keeps issuing instructions that do not need the results while the divide is in progress. When it wants to move a result out, it raises the read strobe for LO or HI. The divider answers with a stall signal in the same cycle, and that stall is high only while the requested register is still empty. The datapath is not pipelined. A second divide request that arrives while one is in progress is held off through the ready signal. It is not dropped, and it is accepted on the first clock edge after the running divide completes.

Top module: `idiv_bg`

## Requirements
- R1: After reset, req_ready is 1, lo_full and hi_full are 0, and a read of either register raises stall.
- R2: lo_full and hi_full rise exactly 42 clock edges after the edge on which a request was accepted, where a request is accepted when req_valid and req_ready are both high at the edge.
- R3: Only one divide is in progress at a time. req_ready is low from the accepting edge until the edge that fills the results. A request held on req_valid during that time is accepted on the next edge, with its own operands.
- R4: The accepting edge clears both full bits.
- R5: With req_signed = 0, the operands are unsigned, LO receives the quotient rounded down and HI receives the remainder.
- R6: With req_signed = 1, the operands are two's complement. The quotient rounds toward zero, which means it is negated when the operand signs differ, and the remainder takes the sign of the dividend. The case 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R7: A zero divisor raises no trap and takes the same 42 cycles. LO becomes 0xFFFFFFFF and HI becomes the dividend unchanged, in both modes.
- R8: LO, HI and the full bits hold their values until the next request is accepted, whatever the read strobes do.
- R9: stall is combinational and high in exactly one case: rd_lo is high while lo_full is 0, or rd_hi is high while hi_full is 0. No read, or a read of a full register, gives stall = 0.
- R10: lo_full and hi_full are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Divide request present |
| req_signed | input | 1 | 1 selects signed division, 0 selects unsigned |
| req_dividend | input | 32 | Dividend |
| req_divisor | input | 32 | Divisor |
| req_ready | output | 1 | Divider idle; a request is accepted this edge |
| rd_lo | input | 1 | Pipeline reads LO this cycle |
| rd_hi | input | 1 | Pipeline reads HI this cycle |
| stall | output | 1 | Requested result register is still empty |
| lo_q | output | 32 | Quotient register |
| hi_q | output | 32 | Remainder register |
| lo_full | output | 1 | LO holds a finished result |
| hi_full | output | 1 | HI holds a finished result |

## Verification
A cycle counter that is off by one shows at the ports as full bits that rise one edge early or late. It also moves req_ready, so the latency measurement and the hold-off test both catch it after a single divide. A wrong sign flag or a wrong iteration state shows only in the LO/HI values when the results are filled, 42 cycles after issue. For that reason, signed, unsigned and zero-divisor operands are each run to completion. A stale full bit is the fastest fault to see: stall is combinational, so it shows on the very cycle that a read of an empty register is attempted.

// File: rtl/idiv_bg.sv
module idiv_bg #(
  parameter int W   = 32,
  parameter int LAT = 42
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_signed,
  input  logic [W-1:0] req_dividend,
  input  logic [W-1:0] req_divisor,
  output logic         req_ready,
  input  logic         rd_lo,
  input  logic         rd_hi,
  output logic         stall,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         lo_full,
  output logic         hi_full
);
  localparam int CW      = $clog2(LAT + 1);
  localparam int STEP_LO = LAT - 1 - W;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [W:0]    rem;
  logic [W-1:0]  quo;
  logic [W-1:0]  dvs;
  logic [W-1:0]  dvd_keep;
  logic          neg_q, neg_r, by_zero;

  wire take = req_valid && !busy;

  wire a_neg = req_signed && req_dividend[W-1];
  wire b_neg = req_signed && req_divisor[W-1];
  wire [W-1:0] a_mag = a_neg ? -req_dividend : req_dividend;
  wire [W-1:0] b_mag = b_neg ? -req_divisor  : req_divisor;

  wire [W:0] shifted = {rem[W-1:0], quo[W-1]};
  wire       ge      = shifted >= {1'b0, dvs};
  wire       do_step = busy && (cnt > CW'(STEP_LO));
  wire       finish  = busy && (cnt == '0);

  wire [W-1:0] q_fin = by_zero ? '1       : (neg_q ? -quo : quo);
  wire [W-1:0] r_fin = by_zero ? dvd_keep : (neg_r ? -rem[W-1:0] : rem[W-1:0]);

  assign req_ready = !busy;
  assign stall     = (rd_lo && !lo_full) || (rd_hi && !hi_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      rem      <= '0;
      quo      <= '0;
      dvs      <= '0;
      dvd_keep <= '0;
      neg_q    <= 1'b0;
      neg_r    <= 1'b0;
      by_zero  <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      lo_full  <= 1'b0;
      hi_full  <= 1'b0;
    end else if (take) begin
      busy     <= 1'b1;
      cnt      <= CW'(LAT - 1);
      rem      <= '0;
      quo      <= a_mag;
      dvs      <= b_mag;
      dvd_keep <= req_dividend;
      by_zero  <= (req_divisor == '0);
      neg_q    <= a_neg ^ b_neg;
      neg_r    <= a_neg;
      lo_full  <= 1'b0;
      hi_full  <= 1'b0;
    end else if (busy) begin
      if (do_step) begin
        rem <= ge ? (shifted - {1'b0, dvs}) : shifted;
        quo <= {quo[W-2:0], ge};
      end
      if (finish) begin
        busy    <= 1'b0;
        lo_q    <= q_fin;
        hi_q    <= r_fin;
        lo_full <= 1'b1;
        hi_full <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/idiv_bg_chk.sv
module idiv_bg_chk #(
  parameter int W   = 32,
  parameter int LAT = 42
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         rd_lo,
  input logic         rd_hi,
  input logic         stall,
  input logic [W-1:0] lo_q,
  input logic [W-1:0] hi_q,
  input logic         lo_full,
  input logic         hi_full
);
  localparam int AGE_MAX = LAT + 2;
  int unsigned age;
  wire acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                 age <= AGE_MAX;
    else if (acc)               age <= 0;
    else if (age < AGE_MAX)     age <= age + 1;
  end

  p_reset_empty_r1: assert property (@(posedge clk)
    $fell(rst_n) |=> (req_ready && !lo_full && !hi_full));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_full) |-> (age == LAT));

  p_ready_returns_with_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $rose(lo_full));

  p_issue_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!lo_full && !hi_full && !req_ready));

  p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_full && !acc) |=> (lo_full && $stable(lo_q) && $stable(hi_q)));

  p_stall_empty_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !lo_full) |-> stall);

  p_no_stall_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |-> !stall);

  p_full_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lo_full == hi_full);
endmodule

bind idiv_bg idiv_bg_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_lo(rd_lo), .rd_hi(rd_hi), .stall(stall), .lo_q(lo_q), .hi_q(hi_q),
  .lo_full(lo_full), .hi_full(hi_full)
);

// File: tb/idiv_bg_tb.sv
`timescale 1ns/1ps
module idiv_bg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_signed = 1'b0;
  logic [31:0] req_dividend = '0;
  logic [31:0] req_divisor = '0;
  logic        req_ready;
  logic        rd_lo = 1'b0;
  logic        rd_hi = 1'b0;
  logic        stall;
  logic [31:0] lo_q, hi_q;
  logic        lo_full, hi_full;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  idiv_bg u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_signed(req_signed),
    .req_dividend(req_dividend), .req_divisor(req_divisor), .req_ready(req_ready),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .stall(stall), .lo_q(lo_q), .hi_q(hi_q),
    .lo_full(lo_full), .hi_full(hi_full)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b, input bit sg,
                                output logic [31:0] q, output logic [31:0] r);
    longint sa, sb;
    if (b == 0) begin
      q = '1; r = a;
    end else if (sg) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q = 32'(sa / sb);
      r = 32'(sa % sb);
    end else begin
      q = a / b; r = a % b;
    end
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit sg);
    @(negedge clk);
    req_valid = 1'b1; req_signed = sg; req_dividend = a; req_divisor = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input bit sg, input string req);
    logic [31:0] q, r;
    int n;
    issue(a, b, sg);
    chk(!lo_full && !hi_full, "R4 full bits cleared", {30'd0, lo_full, hi_full}, 32'd0);
    chk(!req_ready, "R3 ready low while busy", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!lo_full && n < 100) begin
      @(negedge clk);
      n++;
      chk(lo_full == hi_full, "R10 full pair", {30'd0, lo_full, hi_full}, {30'd0, lo_full, lo_full});
    end
    chk(n == 42, "R2 latency", 32'(n), 32'd42);
    model(a, b, sg, q, r);
    chk(lo_q == q, {req, " LO"}, lo_q, q);
    chk(hi_q == r, {req, " HI"}, hi_q, r);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(!lo_full && !hi_full, "R1 empty after reset", {30'd0, lo_full, hi_full}, 32'd0);
    rd_hi = 1'b1;
    #1 chk(stall, "R1 read empty HI stalls", {31'd0, stall}, 32'd1);
    rd_hi = 1'b0;
  endtask

  task automatic t_unsigned;
    run_div(32'd100, 32'd7, 1'b0, "R5 100/7");
    run_div(32'hFFFF_FFFF, 32'd3, 1'b0, "R5 max/3");
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R5 big divisor");
    run_div(32'd5, 32'd9, 1'b0, "R5 small dividend");
  endtask

  task automatic t_signed;
    run_div(-32'sd100, 32'd7, 1'b1, "R6 -100/7");
    run_div(32'd100, -32'sd7, 1'b1, "R6 100/-7");
    run_div(-32'sd100, -32'sd7, 1'b1, "R6 -100/-7");
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R6 overflow");
    chk(lo_q == 32'h8000_0000, "R6 overflow LO", lo_q, 32'h8000_0000);
  endtask

  task automatic t_div0;
    run_div(32'h1234_5678, 32'd0, 1'b0, "R7 unsigned zero");
    run_div(32'hF000_0001, 32'd0, 1'b1, "R7 signed zero");
  endtask

  task automatic t_hold_off;
    logic [31:0] q, r;
    int n;
    issue(32'd1000, 32'd10, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_signed = 1'b0; req_dividend = 32'd77; req_divisor = 32'd5;
    n = 1;
    while (!lo_full && n < 100) begin
      chk(!req_ready, "R3 held off", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      n++;
    end
    chk(lo_q == 32'd100, "R3 first result kept", lo_q, 32'd100);
    chk(req_ready, "R3 ready after finish", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!lo_full && !req_ready, "R3 held request accepted", {30'd0, lo_full, req_ready}, 32'd0);
    n = 0;
    while (!lo_full && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 42, "R3 held request latency", 32'(n), 32'd42);
    model(32'd77, 32'd5, 1'b0, q, r);
    chk(lo_q == q && hi_q == r, "R3 held request result", lo_q, q);
  endtask

  task automatic t_stall;
    issue(32'd50, 32'd6, 1'b0);
    rd_lo = 1'b1;
    #1 chk(stall, "R9 read empty LO", {31'd0, stall}, 32'd1);
    @(negedge clk);
    rd_lo = 1'b0; rd_hi = 1'b0;
    #1 chk(!stall, "R9 no read no stall", {31'd0, stall}, 32'd0);
    rd_hi = 1'b1;
    #1 chk(stall, "R9 read empty HI", {31'd0, stall}, 32'd1);
    rd_hi = 1'b0;
    while (!lo_full) @(negedge clk);
    rd_lo = 1'b1; rd_hi = 1'b1;
    #1 chk(!stall, "R9 read full regs", {31'd0, stall}, 32'd0);
    repeat (5) @(negedge clk);
    chk(lo_q == 32'd8 && hi_q == 32'd2 && lo_full, "R8 results held", lo_q, 32'd8);
    rd_lo = 1'b0; rd_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk(hi_q == 32'd2 && hi_full, "R8 HI held", hi_q, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unsigned();
    t_signed();
    t_div0();
    t_hold_off();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule